// File: doc/BRIEF.md
# Bus Requester Handshake Agent

This block sits between a local client and a shared bus whose ownership passes through a request, grant and acknowledge handshake. When the client asks for the bus, the agent raises a bus request and watches the grant input from the arbitration side. A grant does not hand over the bus at once. The agent also watches the address-strobe and cycle-terminate inputs, and it claims the bus only when the current master's cycle has ended and the grant is still present.

The agent claims the bus by raising grant-acknowledge. In the same cycle it drops its request. It keeps the acknowledge high for the whole tenure and tells the client through an owns-bus output. When the client reports that it is done, the agent drops the acknowledge. It then waits until the grant is seen low before it accepts another client request. All bus-side inputs pass through synchronisers. A short quiet-bus qualifier decides when the previous cycle has finished. The order of transfers and any choice among several requesters are handled elsewhere.

Top module: `busreq_agent`

## Requirements
- R1: While rst_ni is low, and right after it is released, bus_req_o, grant_ack_o and owns_bus_o are all low.
- R2: A high client_req_i with the agent idle raises bus_req_o. bus_req_o then stays high until grant_ack_o rises, even if client_req_i falls.
- R3: While addr_strobe_i or cycle_term_i (both active high) is asserted, grant_ack_o stays low and bus_req_o stays high, even with bus_grant_i asserted.
- R4: grant_ack_o rises only if bus_grant_i is still asserted when the bus becomes quiet. If the grant is withdrawn before the cycle ends, the agent keeps requesting without acknowledging. It acknowledges once the grant returns on a quiet bus.
- R5: bus_req_o falls on the same clock edge at which grant_ack_o rises. The two outputs are never high together.
- R6: owns_bus_o is high exactly while grant_ack_o is high.
- R7: grant_ack_o stays high for as long as client_done_i stays low. A high client_done_i during ownership drops grant_ack_o at the next rising edge.
- R8: After release, a pending client_req_i is ignored while bus_grant_i remains high, and bus_req_o stays low. Once the grant has been seen low, the request is accepted and bus_req_o rises again.
- R9: The bus counts as quiet only after both addr_strobe_i and cycle_term_i have been low for QUIET_CYCLES consecutive synchronised samples. With the defaults (SYNC_STAGES=2, QUIET_CYCLES=1), a pending request on an already quiet bus, and a grant first driven just before a rising edge, give grant_ack_o high after the fourth rising edge and still low after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| client_req_i | input | 1 | Client asks for bus ownership |
| client_done_i | input | 1 | Client has finished its transfers |
| bus_grant_i | input | 1 | Bus grant from arbitration side, active high, asynchronous |
| addr_strobe_i | input | 1 | Current master's address strobe, active high, asynchronous |
| cycle_term_i | input | 1 | Cycle-terminate indication, active high, asynchronous |
| bus_req_o | output | 1 | Bus request |
| grant_ack_o | output | 1 | Grant acknowledge, held during ownership |
| owns_bus_o | output | 1 | Tells the client it owns the bus |

## Verification
The bench checks cases where a grant arrives while the previous master is still busy. It drives the address strobe alone, the terminate alone and both together. A design that ignored either input would acknowledge too early. The bench also withdraws the grant during the wait. A design that latched the grant would acknowledge a bus it was never given. It checks that the agent releases only on done, and it checks the re-request lockout while the grant lingers after release. An agent that skipped this lockout would request again at once. Finally, it checks the exact acknowledge latency on a quiet bus. An extra or missing register in the synchroniser or the decision path would shift that edge.

// File: rtl/busreq_pkg.sv
package busreq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQUEST,
    ST_WAIT_END,
    ST_OWN,
    ST_RELEASE
  } agent_state_e;
endpackage

// File: rtl/busreq_sync.sv
module busreq_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] chain_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          chain_q <= '0;
        end else begin
          chain_q[0] <= d_i;
          for (int s = 1; s < int'(STAGES); s++) chain_q[s] <= chain_q[s-1];
        end
      end
      assign q_o = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/busreq_quiet.sv
module busreq_quiet #(
  parameter int unsigned QUIET_CYCLES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic term_i,
  output logic quiet_o
);
  localparam int unsigned CW = (QUIET_CYCLES < 1) ? 1 : $clog2(QUIET_CYCLES + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(QUIET_CYCLES);

  logic [CW-1:0] cnt_q;
  logic          busy;

  assign busy = strobe_i | term_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (busy)           cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  // reset value counts as busy: no claim straight out of reset
  assign quiet_o = !busy && (cnt_q == CNT_MAX);
endmodule

// File: rtl/busreq_fsm.sv
module busreq_fsm
  import busreq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic done_i,
  input  logic grant_i,
  input  logic quiet_i,
  output logic bus_req_o,
  output logic grant_ack_o
);
  agent_state_e state_q, state_d;
  logic         bus_req_q, ack_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req_i) state_d = ST_REQUEST;
      ST_REQUEST:  if (grant_i) state_d = ST_WAIT_END;
      ST_WAIT_END: begin
        if (!grant_i)     state_d = ST_REQUEST;
        else if (quiet_i) state_d = ST_OWN;
      end
      ST_OWN:      if (done_i) state_d = ST_RELEASE;
      ST_RELEASE:  if (!grant_i) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bus_req_q <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      bus_req_q <= (state_d == ST_REQUEST) || (state_d == ST_WAIT_END);
      ack_q     <= (state_d == ST_OWN);
    end
  end

  assign bus_req_o   = bus_req_q;
  assign grant_ack_o = ack_q;
endmodule

// File: rtl/busreq_agent.sv
module busreq_agent #(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned QUIET_CYCLES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic client_req_i,
  input  logic client_done_i,
  input  logic bus_grant_i,
  input  logic addr_strobe_i,
  input  logic cycle_term_i,
  output logic bus_req_o,
  output logic grant_ack_o,
  output logic owns_bus_o
);
  localparam int unsigned NSYNC = 3;

  logic [NSYNC-1:0] raw_in, sync_q;
  logic grant_s, strobe_s, term_s, quiet;
  logic ack;

  assign raw_in = {bus_grant_i, addr_strobe_i, cycle_term_i};
  assign {grant_s, strobe_s, term_s} = sync_q;

  busreq_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (sync_q)
  );

  busreq_quiet #(.QUIET_CYCLES(QUIET_CYCLES)) u_quiet (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobe_s),
    .term_i  (term_s),
    .quiet_o (quiet)
  );

  busreq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (client_req_i),
    .done_i     (client_done_i),
    .grant_i    (grant_s),
    .quiet_i    (quiet),
    .bus_req_o  (bus_req_o),
    .grant_ack_o(ack)
  );

  assign grant_ack_o = ack;
  assign owns_bus_o  = ack;
endmodule

// File: rtl/busreq_agent_chk.sv
module busreq_agent_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic done_i,
  input logic grant_s_i,
  input logic quiet_i,
  input logic bus_req_i,
  input logic grant_ack_i,
  input logic owns_bus_i
);
  a_r5_req_ack_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_req_i && grant_ack_i));

  a_r2_request_before_own: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(owns_bus_i) |-> $past(bus_req_i));

  a_r4_claim_needs_grant_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_ack_i) |-> ($past(grant_s_i) && $past(quiet_i)));

  a_r3_busy_blocks_claim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !quiet_i |=> !$rose(grant_ack_i));

  a_r7_release_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(grant_ack_i) |-> $past(done_i));

  a_r8_no_instant_rerequest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(grant_ack_i) |=> !bus_req_i);
endmodule

bind busreq_agent busreq_agent_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .done_i     (client_done_i),
  .grant_s_i  (grant_s),
  .quiet_i    (quiet),
  .bus_req_i  (bus_req_o),
  .grant_ack_i(grant_ack_o),
  .owns_bus_i (owns_bus_o)
);

// File: tb/busreq_agent_tb.sv
`timescale 1ns/1ps
module busreq_agent_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic client_req_i = 1'b0, client_done_i = 1'b0;
  logic bus_grant_i = 1'b0, addr_strobe_i = 1'b0, cycle_term_i = 1'b0;
  logic bus_req_o, grant_ack_o, owns_bus_o;
  int   checks = 0, errors = 0;

  always #4 clk = ~clk;

  busreq_agent dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .client_req_i (client_req_i),
    .client_done_i(client_done_i),
    .bus_grant_i  (bus_grant_i),
    .addr_strobe_i(addr_strobe_i),
    .cycle_term_i (cycle_term_i),
    .bus_req_o    (bus_req_o),
    .grant_ack_o  (grant_ack_o),
    .owns_bus_o   (owns_bus_o)
  );

  // vector bits: {strobe busy, term busy, withdraw grant while waiting}
  localparam logic [2:0] VEC [6] = '{3'b100, 3'b010, 3'b110, 3'b101, 3'b011, 3'b000};

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic release_bus();
    client_done_i = 1'b1;
    wait_n(1);
    client_done_i = 1'b0;
    bus_grant_i   = 1'b0;
    client_req_i  = 1'b0;
    wait_n(8);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R1..: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_n(3);
    chk("R1 bus_req in reset", bus_req_o, 1'b0);
    chk("R1 ack in reset", grant_ack_o, 1'b0);
    rst_ni = 1'b1;
    wait_n(2);
    chk("R1 owns after reset", owns_bus_o, 1'b0);

    foreach (VEC[i]) begin
      logic sb, tb, dr;
      {sb, tb, dr} = VEC[i];
      addr_strobe_i = sb;
      cycle_term_i  = tb;
      client_req_i  = 1'b1;
      wait_n(4);
      chk("R2 request raised", bus_req_o, 1'b1);
      client_req_i = 1'b0;
      bus_grant_i  = 1'b1;
      wait_n(8);
      if (sb || tb) begin
        chk("R3 no ack while busy", grant_ack_o, 1'b0);
        chk("R3/R2 request held", bus_req_o, 1'b1);
      end
      if (dr) begin
        bus_grant_i = 1'b0;
        wait_n(6);
      end
      addr_strobe_i = 1'b0;
      cycle_term_i  = 1'b0;
      wait_n(8);
      chk("R4/R9 ack after cycle end", grant_ack_o, !dr);
      chk("R5 request vs ack", bus_req_o, dr);
      chk("R6 owns tracks ack", owns_bus_o, grant_ack_o);
      if (dr) begin
        bus_grant_i = 1'b1;
        wait_n(8);
        chk("R4 ack on returned grant", grant_ack_o, 1'b1);
      end
      release_bus();
      chk("R7 released", grant_ack_o, 1'b0);
    end

    // R9 exact latency on quiet bus
    client_req_i = 1'b1;
    wait_n(4);
    client_req_i = 1'b0;
    bus_grant_i = 1'b1;
    wait_n(3);
    chk("R9 ack low after third edge", grant_ack_o, 1'b0);
    wait_n(1);
    chk("R9 ack high after fourth edge", grant_ack_o, 1'b1);
    chk("R5 request dropped with ack", bus_req_o, 1'b0);

    // R7 tenure held while done low
    wait_n(20);
    chk("R7 ack held", grant_ack_o, 1'b1);
    chk("R6 owns held", owns_bus_o, 1'b1);
    client_done_i = 1'b1;
    wait_n(1);
    client_done_i = 1'b0;
    chk("R7 ack drop one edge after done", grant_ack_o, 1'b0);
    chk("R6 owns dropped", owns_bus_o, 1'b0);

    // R8 lockout while grant lingers
    client_req_i = 1'b1;
    wait_n(10);
    chk("R8 request ignored while granted", bus_req_o, 1'b0);
    chk("R8 no ack", grant_ack_o, 1'b0);
    bus_grant_i = 1'b0;
    wait_n(8);
    chk("R8 request accepted after grant low", bus_req_o, 1'b1);
    bus_grant_i = 1'b1;
    wait_n(8);
    chk("R4 ack in new tenure", grant_ack_o, 1'b1);
    release_bus();

    // R1 asynchronous reset during ownership
    client_req_i = 1'b1;
    bus_grant_i  = 1'b1;
    wait_n(10);
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset clears ack", grant_ack_o, 1'b0);
    chk("R1 async reset clears request", bus_req_o, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule